// File: doc/BRIEF.md
# Vector AND-Test Flag Generator

This unit takes two vector operands of up to 256 bits and turns them into condition flags; it writes no destination. The zero flag reports whether the two operands share any set bit. The carry flag reports whether the second operand has a set bit that the first operand lacks. The remaining arithmetic flags (auxiliary, overflow, parity, sign) are always driven low. A further output, the mixed flag, is high when both the zero flag and the carry flag are clear. It supports a "some overlap and some excess" test in one step.

A width select picks a 128-bit or a 256-bit comparison. In 128-bit mode the upper half of both operands plays no part. The encoding carries a 4-bit register-specifier field that this operation does not use, and it must read 4'b1111. Any other value with the valid strobe high is an illegal encoding. The unit then raises an undefined-operation pulse and leaves the flags as they were. Flags are registered, so a result appears on the clock edge after the accepted request.

Top module: `vtest_flags`

## Requirements
- R1: One cycle after a clock edge with `valid_i`=1 and `spec_i`=4'b1111, `zf_o` is 1 exactly when (`opa_i` AND `opb_i`) is zero over the active width.
- R2: Under the same conditions, `cf_o` is 1 exactly when (`opb_i` AND NOT `opa_i`) is zero over the active width.
- R3: `af_o`, `of_o`, `pf_o` and `sf_o` are 0 in every cycle.
- R4: `wide_i`=1 selects 256 bits. `wide_i`=0 selects bits 127:0, and operand bits 255:128 then have no effect on either flag.
- R5: If `valid_i`=1 and `spec_i`≠4'b1111 at an edge, `undef_o` is 1 for the following cycle. `zf_o`, `cf_o` and `mix_o` keep their previous values.
- R6: If `valid_i`=0 at an edge, `undef_o` is 0 in the following cycle and the flags keep their values, whatever the operands, width and specifier are.
- R7: `mix_o` equals (NOT `zf_o`) AND (NOT `cf_o`) in every cycle.
- R8: While `rst` is high (synchronous, active high), the outputs become `zf_o`=1, `cf_o`=1, `mix_o`=0, `undef_o`=0. These are the flags of two all-zero operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| wide_i | input | 1 | 1 = 256-bit compare, 0 = 128-bit compare |
| spec_i | input | 4 | Unused register-specifier field; must be 4'b1111 |
| opa_i | input | 256 | First operand |
| opb_i | input | 256 | Second operand |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag |
| mix_o | output | 1 | Both zero and carry flags clear |
| af_o | output | 1 | Auxiliary flag, always 0 |
| of_o | output | 1 | Overflow flag, always 0 |
| pf_o | output | 1 | Parity flag, always 0 |
| sf_o | output | 1 | Sign flag, always 0 |
| undef_o | output | 1 | Illegal-encoding pulse |

## Verification
An illegal specifier and a valid request can arrive in the same cycle. That cycle must then raise the undefined pulse and also block the flag update the operands would otherwise cause. The bench first loads a state with both flags clear. It then issues a strobed request with specifier 4'b0111 and operands that would set both flags. It judges the next cycle by requiring `undef_o`=1 with `zf_o`, `cf_o` and `mix_o` unchanged. A following idle cycle must drop the pulse and still hold the flags.

// File: rtl/vtest_pkg.sv
package vtest_pkg;

    localparam int unsigned DATA_W  = 256;
    localparam int unsigned LANE_W  = 128;
    localparam int unsigned CHUNK_W = 32;
    localparam int unsigned SPEC_W  = 4;

    localparam logic [SPEC_W-1:0] SPEC_UNUSED = '1;

    typedef enum logic {
        VW_NARROW = 1'b0,
        VW_WIDE   = 1'b1
    } vwidth_e;

    typedef struct packed {
        logic zf;
        logic cf;
        logic mix;
    } cond_t;

    localparam cond_t COND_RESET = '{zf: 1'b1, cf: 1'b1, mix: 1'b0};

    function automatic cond_t make_cond(input logic and_zero, input logic andn_zero);
        cond_t c;
        c.zf  = and_zero;
        c.cf  = andn_zero;
        c.mix = ~and_zero & ~andn_zero;
        return c;
    endfunction

endpackage

// File: rtl/vtest_lane_mask.sv
module vtest_lane_mask #(
    parameter int unsigned DATA_W = vtest_pkg::DATA_W,
    parameter int unsigned LANE_W = vtest_pkg::LANE_W
) (
    input  vtest_pkg::vwidth_e  width_i,
    output logic [DATA_W-1:0]   keep_o
);
    localparam int unsigned NLANES = DATA_W / LANE_W;

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        if (l == 0) begin : g_base
            assign keep_o[l*LANE_W +: LANE_W] = '1;
        end else begin : g_upper
            assign keep_o[l*LANE_W +: LANE_W] =
                {LANE_W{width_i == vtest_pkg::VW_WIDE}};
        end
    end
endmodule

// File: rtl/vtest_zero_reduce.sv
module vtest_zero_reduce #(
    parameter int unsigned DATA_W  = vtest_pkg::DATA_W,
    parameter int unsigned CHUNK_W = vtest_pkg::CHUNK_W
) (
    input  logic [DATA_W-1:0] vec_i,
    output logic              zero_o
);
    localparam int unsigned NCHUNK = DATA_W / CHUNK_W;

    logic [NCHUNK-1:0] chunk_any;

    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        assign chunk_any[c] = |vec_i[c*CHUNK_W +: CHUNK_W];
    end

    assign zero_o = ~|chunk_any;
endmodule

// File: rtl/vtest_flag_reg.sv
module vtest_flag_reg (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             undef_i,
    input  vtest_pkg::cond_t next_i,
    output vtest_pkg::cond_t cond_o,
    output logic             undef_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cond_o  <= vtest_pkg::COND_RESET;
            undef_o <= 1'b0;
        end else begin
            if (load_i) begin
                cond_o <= next_i;
            end
            undef_o <= undef_i;
        end
    end
endmodule

// File: rtl/vtest_flags.sv
module vtest_flags #(
    parameter int unsigned DATA_W  = vtest_pkg::DATA_W,
    parameter int unsigned LANE_W  = vtest_pkg::LANE_W,
    parameter int unsigned CHUNK_W = vtest_pkg::CHUNK_W,
    parameter int unsigned SPEC_W  = vtest_pkg::SPEC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic              wide_i,
    input  logic [SPEC_W-1:0] spec_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic              zf_o,
    output logic              cf_o,
    output logic              mix_o,
    output logic              af_o,
    output logic              of_o,
    output logic              pf_o,
    output logic              sf_o,
    output logic              undef_o
);
    import vtest_pkg::*;

    vwidth_e           width;
    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] both_bits;
    logic [DATA_W-1:0] excess_bits;
    logic              both_zero;
    logic              excess_zero;
    logic              spec_ok;
    logic              accept;
    logic              illegal;
    cond_t             next_cond;
    cond_t             cur_cond;

    assign width = wide_i ? VW_WIDE : VW_NARROW;

    vtest_lane_mask #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_mask (
        .width_i (width),
        .keep_o  (keep)
    );

    assign both_bits   = opa_i & opb_i & keep;
    assign excess_bits = opb_i & ~opa_i & keep;

    vtest_zero_reduce #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_red_and (
        .vec_i  (both_bits),
        .zero_o (both_zero)
    );

    vtest_zero_reduce #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_red_andn (
        .vec_i  (excess_bits),
        .zero_o (excess_zero)
    );

    assign spec_ok   = (spec_i == SPEC_W'(SPEC_UNUSED));
    assign accept    = valid_i & spec_ok;
    assign illegal   = valid_i & ~spec_ok;
    assign next_cond = make_cond(both_zero, excess_zero);

    vtest_flag_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .load_i  (accept),
        .undef_i (illegal),
        .next_i  (next_cond),
        .cond_o  (cur_cond),
        .undef_o (undef_o)
    );

    assign zf_o  = cur_cond.zf;
    assign cf_o  = cur_cond.cf;
    assign mix_o = cur_cond.mix;
    assign af_o  = 1'b0;
    assign of_o  = 1'b0;
    assign pf_o  = 1'b0;
    assign sf_o  = 1'b0;
endmodule

// File: rtl/vtest_flags_chk.sv
module vtest_flags_chk #(
    parameter int unsigned DATA_W = 256,
    parameter int unsigned LANE_W = 128,
    parameter int unsigned SPEC_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic              wide_i,
    input logic [SPEC_W-1:0] spec_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic              zf_o,
    input logic              cf_o,
    input logic              mix_o,
    input logic              af_o,
    input logic              of_o,
    input logic              pf_o,
    input logic              sf_o,
    input logic              undef_o
);
    logic [DATA_W-1:0] span;
    logic              good_req;
    logic              bad_req;

    assign span     = wide_i ? {DATA_W{1'b1}}
                             : {{(DATA_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
    assign good_req = valid_i && (spec_i == {SPEC_W{1'b1}});
    assign bad_req  = valid_i && (spec_i != {SPEC_W{1'b1}});

    // R1
    zf_result_chk: assert property (@(posedge clk) disable iff (rst)
        good_req |=> (zf_o == $past((opa_i & opb_i & span) == '0)));

    // R2
    cf_result_chk: assert property (@(posedge clk) disable iff (rst)
        good_req |=> (cf_o == $past((opb_i & ~opa_i & span) == '0)));

    // R3
    arith_low_chk: assert property (@(posedge clk) disable iff (rst)
        !(af_o || of_o || pf_o || sf_o));

    // R5
    undef_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bad_req |=> (undef_o && $stable(zf_o) && $stable(cf_o) && $stable(mix_o)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!undef_o && $stable(zf_o) && $stable(cf_o)));

    // R7
    mix_rel_chk: assert property (@(posedge clk) disable iff (rst)
        mix_o == (!zf_o && !cf_o));

    // R8
    reset_val_chk: assert property (@(posedge clk)
        rst |=> (zf_o && cf_o && !mix_o && !undef_o));
endmodule

bind vtest_flags vtest_flags_chk #(
    .DATA_W(DATA_W), .LANE_W(LANE_W), .SPEC_W(SPEC_W)
) u_chk (
    .clk(clk), .rst(rst), .valid_i(valid_i), .wide_i(wide_i), .spec_i(spec_i),
    .opa_i(opa_i), .opb_i(opb_i), .zf_o(zf_o), .cf_o(cf_o), .mix_o(mix_o),
    .af_o(af_o), .of_o(of_o), .pf_o(pf_o), .sf_o(sf_o), .undef_o(undef_o)
);

// File: tb/vtest_flags_test.sv
`timescale 1ns/1ps
module vtest_flags_test;
    localparam int NV = 10;
    localparam logic [255:0] ONES = '1;
    localparam logic [255:0] HI   = {{128{1'b1}}, 128'h0};
    localparam logic [255:0] B255 = {1'b1, 255'h0};
    localparam logic [255:0] B127 = {128'h0, 1'b1, 127'h0};

    localparam logic         TW [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 1, 0};
    localparam logic [255:0] TA [NV] = '{256'h0, 256'h1, 256'h1, 256'h3, HI,
                                         HI, 256'h0, 256'h0, ONES, 256'h0};
    localparam logic [255:0] TB [NV] = '{256'h0, 256'h1, 256'h2, 256'h6, HI,
                                         HI, B255, B255, ONES, B127};
    localparam logic         TZ [NV] = '{1, 0, 1, 0, 1, 0, 1, 1, 0, 1};
    localparam logic         TC [NV] = '{1, 1, 0, 0, 1, 1, 0, 1, 1, 0};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_i = 1'b0;
    logic         wide_i = 1'b0;
    logic [3:0]   spec_i = 4'hF;
    logic [255:0] opa_i = '0;
    logic [255:0] opb_i = '0;
    logic zf_o, cf_o, mix_o, af_o, of_o, pf_o, sf_o, undef_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    vtest_flags uut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .wide_i(wide_i), .spec_i(spec_i),
        .opa_i(opa_i), .opb_i(opb_i), .zf_o(zf_o), .cf_o(cf_o), .mix_o(mix_o),
        .af_o(af_o), .of_o(of_o), .pf_o(pf_o), .sf_o(sf_o), .undef_o(undef_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic check_outs(input string req, input logic z, input logic c, input logic u);
        check(req, "zf", zf_o, z);
        check(req, "cf", cf_o, c);
        check("R7", "mix", mix_o, ~z & ~c);
        check("R3", "af|of|pf|sf", af_o | of_o | pf_o | sf_o, 1'b0);
        check(req, "undef", undef_o, u);
    endtask

    task automatic drive(input logic v, input logic w, input logic [3:0] s,
                         input logic [255:0] a, input logic [255:0] b);
        @(negedge clk);
        valid_i = v; wide_i = w; spec_i = s; opa_i = a; opb_i = b;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check_outs("R8", 1'b1, 1'b1, 1'b0);
        rst = 1'b0;

        // R1 R2 R4: table walk
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, TW[i], 4'hF, TA[i], TB[i]);
            check_outs((i >= 4) ? "R4" : "R1/R2", TZ[i], TC[i], 1'b0);
        end

        // load state with both flags clear (mix=1)
        drive(1'b1, 1'b0, 4'hF, 256'h3, 256'h6);
        check_outs("R7", 1'b0, 1'b0, 1'b0);

        // R5: illegal specifier with operands that would set both flags
        drive(1'b1, 1'b0, 4'b0111, 256'h0, 256'h0);
        check_outs("R5", 1'b0, 1'b0, 1'b1);
        drive(1'b1, 1'b1, 4'b1110, 256'h0, 256'h0);
        check_outs("R5", 1'b0, 1'b0, 1'b1);

        // R6: idle cycle drops pulse, flags hold
        drive(1'b0, 1'b1, 4'hF, 256'h0, 256'h0);
        check_outs("R6", 1'b0, 1'b0, 1'b0);
        // R6: idle with bad specifier raises nothing
        drive(1'b0, 1'b0, 4'h0, 256'h0, ONES);
        check_outs("R6", 1'b0, 1'b0, 1'b0);

        // R4: upper-half difference ignored in narrow mode
        drive(1'b1, 1'b0, 4'hF, HI | 256'h4, HI | 256'h4);
        check_outs("R4", 1'b0, 1'b1, 1'b0);

        // R8: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check_outs("R8", 1'b1, 1'b1, 1'b0);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule